// File: doc/BRIEF.md
# Configuration Lock and Register Preload Controller

This block sits between an external programming or test port and two things: the configuration bit store of a programmable logic array, and the output registers of its macrocells. Through a small command port the programmer can read single configuration bits, program them, set a one-way lock, or start an erase of the whole store. Once the lock is set, every readback returns "programmed" whatever the stored pattern is, and programming is refused. The only way to clear the lock is the full erase, which wipes the pattern in the same operation.

The same block runs the register preload path used for testing state machines. While the preload mode line is held high, all macrocell outputs are forced off, and the levels on the output pins become data. A strobe captures those levels. The capture is only accepted when the pins were steady for a set number of clock edges before the strobe, stayed steady for a set number after it, and the mode line stayed high for a set number after it. An accepted capture raises one load pulse towards the macrocells that are in registered mode. A capture that breaks a window is dropped, and it raises a sticky error flag. While the lock is set, preload is refused.

Top module: `cfgsec_ctrl`

## Requirements
- R1: After reset, `rd_valid`, `busy`, `out_disable`, `ld_en` and `preload_err` are all 0, and every configuration bit and the lock read back as 0.
- R2: A read command (`cmd_op` = 2'b00) accepted at a clock edge raises `rd_valid` for exactly the following cycle, with `rd_data` holding the addressed bit. No other command raises `rd_valid`.
- R3: A program command (`cmd_op` = 2'b01) sets the addressed bit to 1 when the lock is clear. While the lock is set it has no effect, and the bit still reads 0 after the lock has been erased.
- R4: A lock command (`cmd_op` = 2'b11) sets the lock. From then on every read returns 1 for every address.
- R5: While the lock is set, the preload mode line neither disables the outputs nor lets a strobe load any register, and a strobe raises no error.
- R6: An erase command (`cmd_op` = 2'b10) holds `busy` high for exactly ERASE_CYC cycles. Commands that arrive while `busy` is high are ignored. When `busy` falls, every configuration bit and the lock are 0. The lock never clears any other way.
- R7: `out_disable` goes to 1 one cycle after the preload mode line rises, and back to 0 one cycle after it falls.
- R8: The rising edge of `latch_stb` is the strobe. Suppose the mode is high, the pins have held their value for SETUP_CYC edges before the strobe edge, and both the pins and the mode hold for the windows after it. Then, WIN = max(HOLD_CYC, MODE_HOLD_CYC) edges after the strobe, `ld_en` equals `cell_is_reg` for one cycle and `ld_data` equals the captured pins. No bit of `ld_en` is ever set for a cell whose `cell_is_reg` bit is 0.
- R9: A strobe whose pins held for fewer than SETUP_CYC prior edges loads nothing and sets `preload_err`. The flag stays set until reset.
- R10: A pin change within HOLD_CYC edges after an accepted strobe cancels the load and sets `preload_err`.
- R11: The mode line dropping within MODE_HOLD_CYC edges after an accepted strobe cancels the load and sets `preload_err`.
- R12: A strobe while the mode line is low is ignored: no load and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 read, 01 program, 10 erase, 11 lock |
| cmd_addr | input | $clog2(CFG_BITS) | Configuration bit address |
| rd_valid | output | 1 | Readback data valid |
| rd_data | output | 1 | Readback bit (1 = programmed) |
| busy | output | 1 | Erase in progress |
| preload_mode | input | 1 | Preload mode line |
| latch_stb | input | 1 | Preload strobe, acts on its rising edge |
| pin_in | input | CELLS | Levels seen on the output pins |
| cell_is_reg | input | CELLS | Per-cell flag: macrocell is in registered mode |
| out_disable | output | 1 | Force all output buffers off |
| ld_en | output | CELLS | Per-cell register load pulse |
| ld_data | output | CELLS | Value to load into each register |
| preload_err | output | 1 | Sticky preload timing error |

## Verification
Readback is registered, so a read driven before edge E is checked just after E, and `busy` likewise shows up one edge after the erase command. It then falls exactly ERASE_CYC edges after that command. `out_disable` trails the mode line by one edge. The bench samples at the falling clock edge, so every check sees the values settled by the last rising edge. For preload, the strobe edge is counted from the edge at which the pins last changed. The load pulse is expected WIN edges after the strobe edge and nowhere else. The bench therefore watches `ld_en` in every cycle of the window, not only at the due edge. An error flag is checked one edge after the offending edge.

// File: rtl/cfgsec_pkg.sv
package cfgsec_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_LOCK  = 2'b11
    } cfg_op_e;
endpackage

// File: rtl/cfgsec_store.sv
module cfgsec_store
    import cfgsec_pkg::*;
#(
    parameter int CFG_BITS  = 64,
    parameter int ERASE_CYC = 6,
    localparam int AW = $clog2(CFG_BITS),
    localparam int CW = $clog2(ERASE_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    output logic          rd_valid,
    output logic          rd_data,
    output logic          busy,
    output logic          locked
);
    typedef struct packed {
        logic [CFG_BITS-1:0] cfg;
        logic                lock;
        logic                busy;
        logic [CW-1:0]       cnt;
        logic                rd_vld;
        logic                rd_bit;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.rd_vld = 1'b0;
        if (s_q.busy) begin
            // erase sequencer: wipe pattern and lock together at the end
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                s_d.cfg  = '0;
                s_d.lock = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (cmd_valid) begin
            case (cfg_op_e'(cmd_op))
                OP_READ: begin
                    s_d.rd_vld = 1'b1;
                    s_d.rd_bit = s_q.lock | s_q.cfg[cmd_addr];
                end
                OP_PROG: begin
                    if (!s_q.lock) s_d.cfg[cmd_addr] = 1'b1;
                end
                OP_ERASE: begin
                    s_d.busy = 1'b1;
                    s_d.cnt  = CW'(ERASE_CYC - 1);
                end
                default: s_d.lock = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid = s_q.rd_vld;
    assign rd_data  = s_q.rd_bit;
    assign busy     = s_q.busy;
    assign locked   = s_q.lock;
endmodule

// File: rtl/cfgsec_preload.sv
module cfgsec_preload #(
    parameter int CELLS         = 10,
    parameter int SETUP_CYC     = 2,
    parameter int HOLD_CYC      = 1,
    parameter int MODE_HOLD_CYC = 3,
    localparam int WIN = (HOLD_CYC > MODE_HOLD_CYC) ? HOLD_CYC : MODE_HOLD_CYC,
    localparam int SW  = $clog2(SETUP_CYC + 1),
    localparam int EW  = $clog2(WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic             locked,
    input  logic             latch_stb,
    input  logic [CELLS-1:0] pin_in,
    input  logic [CELLS-1:0] cell_is_reg,
    output logic [CELLS-1:0] ld_en,
    output logic [CELLS-1:0] ld_data,
    output logic             err
);
    typedef struct packed {
        logic [CELLS-1:0] prev_pins;
        logic [SW-1:0]    run;
        logic             stb_prev;
        logic             pend;
        logic [EW-1:0]    el;
        logic [CELLS-1:0] cap;
        logic [CELLS-1:0] ld_en;
        logic [CELLS-1:0] ld_data;
        logic             err;
    } pl_t;

    pl_t s_d, s_q;

    logic          same;
    logic          setup_ok;
    logic          strobe;
    logic          viol;
    logic [EW-1:0] el_n;

    always_comb begin
        s_d           = s_q;
        s_d.ld_en     = '0;
        s_d.prev_pins = pin_in;
        s_d.stb_prev  = latch_stb;

        same     = (pin_in == s_q.prev_pins);
        setup_ok = same && ((32'(s_q.run) + 1) >= SETUP_CYC);
        strobe   = latch_stb && !s_q.stb_prev;
        el_n     = s_q.el + 1'b1;
        viol     = 1'b0;

        // run length of unchanged pin levels, saturating at the setup need
        if (!same)                          s_d.run = '0;
        else if (32'(s_q.run) < SETUP_CYC)  s_d.run = s_q.run + 1'b1;

        if (s_q.pend) begin
            viol = ((32'(el_n) <= HOLD_CYC) && (pin_in != s_q.cap)) ||
                   ((32'(el_n) <= MODE_HOLD_CYC) && !mode);
            if (viol) begin
                s_d.pend = 1'b0;
                s_d.err  = 1'b1;
            end else if (32'(el_n) == WIN) begin
                s_d.pend = 1'b0;
                if (!locked) begin
                    s_d.ld_en   = cell_is_reg;
                    s_d.ld_data = s_q.cap;
                end
            end else begin
                s_d.el = el_n;
            end
        end else if (strobe && mode && !locked) begin
            if (setup_ok) begin
                s_d.pend = 1'b1;
                s_d.el   = '0;
                s_d.cap  = pin_in;
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ld_en   = s_q.ld_en;
    assign ld_data = s_q.ld_data;
    assign err     = s_q.err;
endmodule

// File: rtl/cfgsec_ctrl.sv
module cfgsec_ctrl #(
    parameter int CELLS         = 10,
    parameter int CFG_BITS      = 64,
    parameter int ERASE_CYC     = 6,
    parameter int SETUP_CYC     = 2,
    parameter int HOLD_CYC      = 1,
    parameter int MODE_HOLD_CYC = 3,
    localparam int AW = $clog2(CFG_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    output logic             rd_valid,
    output logic             rd_data,
    output logic             busy,
    input  logic             preload_mode,
    input  logic             latch_stb,
    input  logic [CELLS-1:0] pin_in,
    input  logic [CELLS-1:0] cell_is_reg,
    output logic             out_disable,
    output logic [CELLS-1:0] ld_en,
    output logic [CELLS-1:0] ld_data,
    output logic             preload_err
);
    logic lock_w;
    logic od_d, od_q;

    cfgsec_store #(
        .CFG_BITS  (CFG_BITS),
        .ERASE_CYC (ERASE_CYC)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .busy      (busy),
        .locked    (lock_w)
    );

    cfgsec_preload #(
        .CELLS         (CELLS),
        .SETUP_CYC     (SETUP_CYC),
        .HOLD_CYC      (HOLD_CYC),
        .MODE_HOLD_CYC (MODE_HOLD_CYC)
    ) u_preload (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (preload_mode),
        .locked      (lock_w),
        .latch_stb   (latch_stb),
        .pin_in      (pin_in),
        .cell_is_reg (cell_is_reg),
        .ld_en       (ld_en),
        .ld_data     (ld_data),
        .err         (preload_err)
    );

    always_comb begin
        od_d = preload_mode && !lock_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) od_q <= 1'b0;
        else        od_q <= od_d;
    end

    assign out_disable = od_q;
endmodule

// File: rtl/cfgsec_ctrl_chk.sv
module cfgsec_ctrl_chk #(
    parameter int CELLS = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             preload_mode,
    input logic             lock,
    input logic             busy,
    input logic             rd_valid,
    input logic             rd_data,
    input logic [CELLS-1:0] cell_is_reg,
    input logic [CELLS-1:0] ld_en,
    input logic             out_disable
);
    a_r4_locked_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(lock)) |-> rd_data);

    a_r5_no_load_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock) |-> (ld_en == '0));

    a_r6_unlock_only_by_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> ($past(busy) && !busy));

    a_r6_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !rd_valid);

    a_r7_disable_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        out_disable |-> $past(preload_mode));

    a_r8_load_regs_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en & ~$past(cell_is_reg)) == '0);

    a_r8_load_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|ld_en) |=> (ld_en == '0));
endmodule

bind cfgsec_ctrl cfgsec_ctrl_chk #(.CELLS(CELLS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .preload_mode (preload_mode),
    .lock         (lock_w),
    .busy         (busy),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .cell_is_reg  (cell_is_reg),
    .ld_en        (ld_en),
    .out_disable  (out_disable)
);

// File: tb/cfgsec_ctrl_bench.sv
module cfgsec_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CELLS = 10;
    localparam int NBITS = 64;
    localparam int ERC   = 6;
    localparam int SETUP = 2;
    localparam int HOLD  = 1;
    localparam int MHOLD = 3;
    localparam int WIN   = (HOLD > MHOLD) ? HOLD : MHOLD;
    localparam int AW    = $clog2(NBITS);
    localparam logic [1:0] RD = 2'b00, PG = 2'b01, ER = 2'b10, LK = 2'b11;
    localparam logic [CELLS-1:0] REGMASK = 10'h2AA;

    // vector: {op[1:0], addr[5:0], expected read bit}
    localparam int NVEC = 8;
    localparam logic [8:0] VEC [NVEC] = '{
        {PG, 6'd5,  1'b0}, {RD, 6'd5,  1'b1}, {RD, 6'd6, 1'b0}, {PG, 6'd63, 1'b0},
        {RD, 6'd63, 1'b1}, {RD, 6'd0,  1'b0}, {PG, 6'd0, 1'b0}, {RD, 6'd0,  1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'b00;
    logic [AW-1:0]    cmd_addr = '0;
    logic             rd_valid, rd_data, busy;
    logic             preload_mode = 1'b0;
    logic             latch_stb = 1'b0;
    logic [CELLS-1:0] pin_in = '0;
    logic [CELLS-1:0] cell_is_reg = REGMASK;
    logic             out_disable;
    logic [CELLS-1:0] ld_en, ld_data;
    logic             preload_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgsec_ctrl #(
        .CELLS(CELLS), .CFG_BITS(NBITS), .ERASE_CYC(ERC),
        .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .MODE_HOLD_CYC(MHOLD)
    ) u_cfgsec_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .preload_mode(preload_mode), .latch_stb(latch_stb), .pin_in(pin_in),
        .cell_is_reg(cell_is_reg), .out_disable(out_disable), .ld_en(ld_en),
        .ld_data(ld_data), .preload_err(preload_err)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_valid = 1'b0; preload_mode = 1'b0; latch_stb = 1'b0;
        pin_in = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic issue(input logic [1:0] op, input int addr);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr);
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int addr, input logic exp);
        issue(RD, addr);
        check({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
        check({tag, " rd_data"}, 32'(rd_data), 32'(exp));
    endtask

    // pins set, wait the given edges, then one strobe edge
    task automatic strobe_after(input logic [CELLS-1:0] pins, input int edges);
        pin_in = pins;
        repeat (edges) tick();
        latch_stb = 1'b1;
        tick();
        latch_stb = 1'b0;
    endtask

    task automatic watch_no_load(input string tag, input int n);
        logic seen = 1'b0;
        repeat (n) begin
            tick();
            if (ld_en != '0) seen = 1'b1;
        end
        check(tag, 32'(seen), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 rd_valid", 32'(rd_valid), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 out_disable", 32'(out_disable), 0);
        check("R1 ld_en", 32'(ld_en), 0);
        check("R1 err", 32'(preload_err), 0);
        rd_chk("R1 cfg clear", 17, 1'b0);

        // R7 mode line to output disable, R8 accepted preload
        preload_mode = 1'b1;
        tick();
        check("R7 disable on", 32'(out_disable), 1);
        strobe_after(10'h1C5, SETUP);
        repeat (WIN - 1) tick();
        check("R8 no early load", 32'(ld_en), 0);
        tick();
        check("R8 ld_en mask", 32'(ld_en), 32'(REGMASK));
        check("R8 ld_data", 32'(ld_data), 32'h1C5);
        tick();
        check("R8 single pulse", 32'(ld_en), 0);
        check("R8 no error", 32'(preload_err), 0);
        preload_mode = 1'b0;
        tick();
        check("R7 disable off", 32'(out_disable), 0);

        // R12 strobe outside preload mode
        strobe_after(10'h0AA, SETUP);
        watch_no_load("R12 no load", WIN + 1);
        check("R12 no error", 32'(preload_err), 0);

        // R9 setup violation, sticky flag
        preload_mode = 1'b1;
        tick();
        strobe_after(10'h0F0, SETUP - 1);
        check("R9 error set", 32'(preload_err), 1);
        watch_no_load("R9 no load", WIN + 1);
        check("R9 error sticky", 32'(preload_err), 1);
        do_reset();

        // R10 hold violation
        preload_mode = 1'b1;
        tick();
        strobe_after(10'h033, SETUP);
        pin_in = 10'h034;
        tick();
        check("R10 error set", 32'(preload_err), 1);
        watch_no_load("R10 no load", WIN + 1);
        do_reset();

        // R11 mode-hold violation
        preload_mode = 1'b1;
        tick();
        strobe_after(10'h155, SETUP);
        preload_mode = 1'b0;
        tick();
        check("R11 error set", 32'(preload_err), 1);
        watch_no_load("R11 no load", WIN + 1);
        do_reset();

        // R2 R3 vector walk
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][8:7], int'(VEC[i][6:1]));
            if (VEC[i][8:7] == RD) begin
                check($sformatf("R2 vec%0d valid", i), 32'(rd_valid), 1);
                check($sformatf("R3 vec%0d data", i), 32'(rd_data), 32'(VEC[i][0]));
            end else begin
                check($sformatf("R2 vec%0d no valid", i), 32'(rd_valid), 0);
            end
        end

        // R4 lock reads ones; R3 program refused while locked
        issue(LK, 0);
        rd_chk("R4 unprogrammed reads 1", 6, 1'b1);
        rd_chk("R4 other reads 1", 33, 1'b1);
        issue(PG, 9);

        // R5 lock blocks preload and output disable
        preload_mode = 1'b1;
        tick();
        check("R5 outputs stay on", 32'(out_disable), 0);
        strobe_after(10'h2F0, SETUP);
        watch_no_load("R5 no load", WIN + 1);
        check("R5 no error", 32'(preload_err), 0);
        preload_mode = 1'b0;
        tick();

        // R6 erase
        issue(ER, 0);
        check("R6 busy up", 32'(busy), 1);
        issue(RD, 5);
        check("R6 read ignored while busy", 32'(rd_valid), 0);
        repeat (ERC - 3) tick();
        check("R6 busy held", 32'(busy), 1);
        tick();
        check("R6 busy high for ERASE_CYC", 32'(busy), 1);
        tick();
        check("R6 busy down", 32'(busy), 0);
        rd_chk("R6 pattern wiped", 5, 1'b0);
        rd_chk("R6 lock cleared", 6, 1'b0);
        rd_chk("R3 locked program had no effect", 9, 1'b0);
        issue(PG, 9);
        rd_chk("R3 program after unlock", 9, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule